// File: doc/BRIEF.md
# Atomic Bit-Modify Control Register Bank

This block holds a small bank of 32-bit control registers for a peripheral. It sits on a simple word-addressed bus with address, write data, write strobe, read strobe and read data. Every register occupies a slot of four consecutive words, which is 16 bytes. The four words in a slot are aliases of the same register. The first alias takes a plain write. The other three change only the bits that are ones in the write data: one clears them, one sets them and one toggles them. Software can therefore change a single field in one bus write, with no read-modify-write sequence.

Each register has two parameters: a mask of read-only bits and a reset value. Read-only bits always show the matching bits of a hardware status input, and no form of bus write can change them. Writable bits are held in flops and are loaded from the reset value on a synchronous reset. Reads return data one cycle after the read strobe. A read at an address beyond the last register returns zero, and a write there has no effect.

Top module: `atomic_reg_bank`

## Requirements
- R1: The bus address is a word index. Bits [1:0] select the write form: 0 is plain, 1 is clear, 2 is set and 3 is invert. The bits above them select the register slot, so slot k covers byte offsets 16k to 16k+15.
- R2: A plain write loads the write data into the writable bits of the selected register.
- R3: A clear write forces to zero only the writable bits whose write-data bit is one. Every other bit keeps its value, so a single data bit clears a single bit.
- R4: A set write ORs the write data into the writable bits. With read-only mask 0xC0A08800 and value 0x01453320, setting 0xFFFFFFFF reads back 0x3F5F77FF.
- R5: An invert write XORs the write data into the writable bits. Inverting 0x1 twice first flips bit 0 and then restores it.
- R6: No write form changes a bit that is in the read-only mask. Those bits always read as the register's slice of `hw_status`. For example, mask 0xFFFFFFC0 with a set of 0xFFFFFFFF reads 0x3F, and mask 0x0000031D with value 0x1610 still reads 0x1610 after an invert of 0x1.
- R7: `rd_data` shows the register value one cycle after `rd_en`, from any of the four aliases, and holds that value while `rd_en` is low.
- R8: A read of a slot index at or above NUM_REGS returns zero. A write to such a slot changes no register.
- R9: Each write takes effect in one clock edge. A read in the same cycle returns the old value, and a read in the next cycle returns the new value.
- R10: A synchronous reset loads each register's reset value into its writable bits and clears `rd_data`.
- R11: A write changes only the register it addresses. All other registers keep their writable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | ADDR_W | Word address: register slot and write form |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W | Write data, or bit selection for clear, set and invert |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W | Registered read data |
| hw_status | input | NUM_REGS*DATA_W | Read-only bit sources, register k in slice k |

## Verification
A wrong bit in any register's stored state reaches `rd_data` one cycle after the next read of that register, at any of its aliases. The bench keeps a behavioural model of every register and compares `rd_data` on every clock. It also reads every register after each burst of random traffic, so a corrupted neighbour or a leaked read-only bit shows up within a few cycles. Wrong alias decoding shows up on the first read that follows the write, because the clear, set and invert results differ from one another for the chosen data.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Write form selected by the two low word-address bits
    typedef enum logic [1:0] {
        FORM_PLAIN = 2'd0,
        FORM_CLR   = 2'd1,
        FORM_SET   = 2'd2,
        FORM_INV   = 2'd3
    } wr_form_e;

endpackage

// File: rtl/arb_decode.sv
module arb_decode
    import arb_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int NUM_REGS = 4
) (
    input  logic [ADDR_W-1:0]   addr,
    output wr_form_e            form,
    output logic [NUM_REGS-1:0] sel,
    output logic                hit
);
    localparam int SLOT_W = ADDR_W - 2;

    logic [SLOT_W-1:0] slot;

    always_comb begin
        slot = addr[ADDR_W-1:2];
        form = wr_form_e'(addr[1:0]);
        hit  = ({1'b0, slot} < (SLOT_W+1)'(NUM_REGS));
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_sel
        assign sel[g] = (slot == SLOT_W'(g));
    end

endmodule

// File: rtl/arb_cell.sv
module arb_cell
    import arb_pkg::*;
#(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RO_MASK = '0,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_sel,
    input  wr_form_e          form,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] value
);
    localparam logic [DATA_W-1:0] WMASK = ~RO_MASK;

    typedef struct packed {
        logic [DATA_W-1:0] bits;
    } cell_t;

    cell_t cell_d, cell_q;
    logic [DATA_W-1:0] upd;

    always_comb begin
        unique case (form)
            FORM_PLAIN: upd = wdata;
            FORM_CLR:   upd = cell_q.bits & ~wdata;
            FORM_SET:   upd = cell_q.bits | wdata;
            FORM_INV:   upd = cell_q.bits ^ wdata;
            default:    upd = cell_q.bits;
        endcase
        cell_d = cell_q;
        if (wr_sel) begin
            cell_d.bits = upd & WMASK;
        end
        value = cell_q.bits | (status & RO_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cell_q.bits <= RST_VAL & WMASK;
        end else begin
            cell_q <= cell_d;
        end
    end

    assert_plain_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && form == FORM_PLAIN) |=> ((value & WMASK) == ($past(wdata) & WMASK)));

    assert_clr_hit_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && form == FORM_CLR) |=> ((value & $past(wdata) & WMASK) == '0));

    assert_clr_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && form == FORM_CLR) |=> (((value ^ $past(value)) & ~$past(wdata) & WMASK) == '0));

    assert_set_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && form == FORM_SET) |=> ((value & $past(wdata) & WMASK) == ($past(wdata) & WMASK)));

    assert_inv_R5: assert property (@(posedge clk) disable iff (rst)
        (wr_sel && form == FORM_INV) |=> (((value ^ $past(value)) & WMASK) == ($past(wdata) & WMASK)));

    assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> (((value ^ $past(value)) & WMASK) == '0));

endmodule

// File: rtl/arb_readmux.sv
module arb_readmux #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             rd_en,
    input  logic                             hit,
    input  logic [NUM_REGS-1:0]              sel,
    input  logic [NUM_REGS-1:0][DATA_W-1:0]  values,
    output logic [DATA_W-1:0]                rd_data
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_t;

    rd_t rd_d, rd_q;
    logic [DATA_W-1:0] picked;

    always_comb begin
        picked = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel[i]) begin
                picked = picked | values[i];
            end
        end
        rd_d = rd_q;
        if (rd_en) begin
            rd_d.data = hit ? picked : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q.data <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q.data;

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rd_data == '0));

    assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

endmodule

// File: rtl/atomic_reg_bank.sv
module atomic_reg_bank
    import arb_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 4,
    parameter int ADDR_W   = 6,
    parameter logic [NUM_REGS-1:0][DATA_W-1:0] RO_MASK = {
        32'hFFFF0000, 32'h0000031D, 32'hFFFFFFC0, 32'hC0A08800},
    parameter logic [NUM_REGS-1:0][DATA_W-1:0] RST_VAL = {
        32'h0000A5A5, 32'h00001610, 32'h00000000, 32'h01453320}
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [ADDR_W-1:0]            addr,
    input  logic                         wr_en,
    input  logic [DATA_W-1:0]            wr_data,
    input  logic                         rd_en,
    output logic [DATA_W-1:0]            rd_data,
    input  logic [NUM_REGS*DATA_W-1:0]   hw_status
);
    wr_form_e                            form;
    logic [NUM_REGS-1:0]                 sel;
    logic                                hit;
    logic [NUM_REGS-1:0][DATA_W-1:0]     values;

    arb_decode #(
        .ADDR_W   (ADDR_W),
        .NUM_REGS (NUM_REGS)
    ) u_decode (
        .addr (addr),
        .form (form),
        .sel  (sel),
        .hit  (hit)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_cell
        arb_cell #(
            .DATA_W  (DATA_W),
            .RO_MASK (RO_MASK[g]),
            .RST_VAL (RST_VAL[g])
        ) u_cell (
            .clk    (clk),
            .rst    (rst),
            .wr_sel (wr_en & sel[g]),
            .form   (form),
            .wdata  (wr_data),
            .status (hw_status[g*DATA_W +: DATA_W]),
            .value  (values[g])
        );
    end

    arb_readmux #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS)
    ) u_readmux (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rd_en),
        .hit     (hit),
        .sel     (sel),
        .values  (values),
        .rd_data (rd_data)
    );

    assert_reset_R10: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: tb/atomic_reg_bank_tb.sv
`timescale 1ns/1ps
module atomic_reg_bank_tb;
    localparam int NR = 4;
    localparam int DW = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] rd_data;
    logic [NR*DW-1:0] hw_status;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [DW-1:0] ro   [NR];
    logic [DW-1:0] rstv [NR];
    logic [DW-1:0] store[NR];
    logic [DW-1:0] stat [NR];
    logic [DW-1:0] exp_rd;

    always #2 clk = ~clk;

    atomic_reg_bank u_dut (
        .clk       (clk),
        .rst       (rst),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .hw_status (hw_status)
    );

    always_comb begin
        for (int i = 0; i < NR; i++) hw_status[i*DW +: DW] = stat[i];
    end

    function automatic logic [DW-1:0] model_val(int idx);
        if (idx >= NR) return '0;
        return store[idx] | (stat[idx] & ro[idx]);
    endfunction

    function automatic logic [AW-1:0] mk(int idx, int form);
        return AW'(idx * 4 + form);
    endfunction

    task automatic check(logic [DW-1:0] act, logic [DW-1:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    // one bus cycle, compared against the model after the edge
    task automatic step(bit w, bit r, int idx, int form, logic [DW-1:0] d, string tag);
        logic [DW-1:0] nv;
        addr = mk(idx, form); wr_en = w; rd_en = r; wr_data = d;
        if (r) exp_rd = model_val(idx);
        @(posedge clk); #1;
        check(rd_data, exp_rd, tag);
        if (w && idx < NR) begin
            case (form)
                0: nv = d;
                1: nv = store[idx] & ~d;
                2: nv = store[idx] | d;
                default: nv = store[idx] ^ d;
            endcase
            store[idx] = nv & ~ro[idx];
        end
        wr_en = 0; rd_en = 0;
    endtask

    task automatic rd_lit(int idx, int form, logic [DW-1:0] lit, string tag);
        step(0, 1, idx, form, '0, tag);
        check(rd_data, lit, tag);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        ro[0] = 32'hC0A08800; rstv[0] = 32'h01453320;
        ro[1] = 32'hFFFFFFC0; rstv[1] = 32'h00000000;
        ro[2] = 32'h0000031D; rstv[2] = 32'h00001610;
        ro[3] = 32'hFFFF0000; rstv[3] = 32'h0000A5A5;
        stat[0] = 32'h0; stat[1] = 32'h0; stat[2] = 32'h00000210; stat[3] = 32'h12340000;
        for (int i = 0; i < NR; i++) store[i] = rstv[i] & ~ro[i];
        exp_rd = '0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        check(rd_data, 32'h0, "R10 rd_data after reset");
        for (int i = 0; i < NR; i++) step(0, 1, i, 0, '0, "R10 reset value");
        rd_lit(0, 0, 32'h01453320, "R10 reg0 reset");
        rd_lit(3, 0, 32'h1234A5A5, "R10 reg3 reset");

        // R4 set with read-only mask
        step(1, 0, 0, 2, 32'hFFFFFFFF, "R4 set");
        rd_lit(0, 0, 32'h3F5F77FF, "R4 set readback");
        // R5 invert twice
        step(1, 0, 0, 3, 32'h1, "R5 inv");
        rd_lit(0, 3, 32'h3F5F77FE, "R5 inv once");
        step(1, 0, 0, 3, 32'h1, "R5 inv");
        rd_lit(0, 1, 32'h3F5F77FF, "R5 inv twice");
        // R3 single-bit clear
        step(1, 0, 0, 1, 32'h2, "R3 clr");
        rd_lit(0, 2, 32'h3F5F77FD, "R3 single bit clear");
        // R6 read-only protection
        step(1, 0, 1, 2, 32'hFFFFFFFF, "R6 set");
        rd_lit(1, 0, 32'h0000003F, "R6 mask 0xFFFFFFC0");
        step(1, 0, 2, 3, 32'h1, "R6 inv ro bit");
        rd_lit(2, 0, 32'h00001610, "R6 inv on ro bit");
        step(1, 0, 2, 0, 32'h0, "R2 plain");
        rd_lit(2, 1, 32'h00000210, "R2 plain keeps ro bits");
        stat[2] = 32'h0000031D;
        rd_lit(2, 2, 32'h0000031D, "R6 ro follows status");
        // R2 plain write
        step(1, 0, 3, 0, 32'hDEADBEEF, "R2 plain");
        rd_lit(3, 3, 32'h1234BEEF, "R2 plain readback");
        // R8 out of range
        step(1, 0, 5, 2, 32'hFFFFFFFF, "R8 write miss");
        rd_lit(5, 0, 32'h0, "R8 read miss");
        rd_lit(15, 3, 32'h0, "R8 read top slot");
        for (int i = 0; i < NR; i++) step(0, 1, i, i, '0, "R11 R8 others intact");
        // R9 same-cycle read sees old value, next cycle sees new
        step(1, 1, 1, 0, 32'h15, "R9 same cycle old");
        check(rd_data, 32'h3F, "R9 read old value");
        rd_lit(1, 1, 32'h15, "R9 next cycle new");
        // R7 hold while idle
        step(0, 0, 0, 0, '0, "R7 hold");
        check(rd_data, 32'h15, "R7 hold value");
        // random traffic, model compared every cycle
        for (int n = 0; n < 2000; n++) begin
            int idx = int'($urandom_range(0, 5));
            int fm  = int'($urandom_range(0, 3));
            bit w   = 1'($urandom);
            bit r   = 1'($urandom);
            if (n % 97 == 0) stat[$urandom_range(0, NR-1)] = $urandom;
            step(w, r, idx, fm, $urandom, "R1 R3 R4 R5 R11 random");
        end
        for (int i = 0; i < NR; i++) step(0, 1, i, 0, '0, "R6 final sweep");
        // R10 reset mid-run
        rst = 1; @(posedge clk); #1; rst = 0;
        for (int i = 0; i < NR; i++) store[i] = rstv[i] & ~ro[i];
        exp_rd = '0;
        check(rd_data, 32'h0, "R10 reset again");
        for (int i = 0; i < NR; i++) step(0, 1, i, 0, '0, "R10 reset reload");
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule